// File: doc/BRIEF.md
# Holdover Frequency Offset Controller

This block sits between a digital loop filter and a digitally controlled oscillator and supplies the offset word that steers the oscillator. While at least one reference input is valid, the live offset from the loop passes through one register to the output. On every sample strobe, the block also records the live offset into a short history line and into a first-order low-pass average.

When every reference reports loss of signal, the block enters holdover. It raises an alarm and replaces the live word with a holdover value. The value is chosen by a mode input: the centre of the tuning range, the offset recorded a fixed number of strobes earlier, or the long-term average. In average mode the output does not jump. It starts from the last live value and walks toward the average by a bounded step on each strobe.

A gapped-clock flag delays holdover entry by two monitor periods, so that an expected gap does not trigger it. The block has no free-run state. It stays in holdover until a reference comes back.

Top module: `hold_offset_ctl`

## Requirements
- R1: While `rst_n` is low, `ofs_out` is 0, `hold_alarm` is 0 and `evt_pulse` is 0.
- R2: While not in holdover, `ofs_out` equals the `live_ofs` value sampled at the previous clock edge.
- R3: Holdover is entered only when every bit of `ref_los` is 1. Any pattern with at least one 0 bit leaves `hold_alarm` at 0 and the output tracking.
- R4: With `gap_mode` = 0, `hold_alarm` rises on the edge that first samples all `ref_los` bits at 1. `evt_pulse` is high for exactly the one cycle after each edge at which `hold_alarm` changes.
- R5: With `gap_mode` = 1, `hold_alarm` rises 2×`mon_period` cycles later than it would with `gap_mode` = 0. If any reference returns during that wait, holdover is not entered.
- R6: `tgt_mode` codes 0 and 3 select the centre target, which is an offset of 0. In these modes the output takes the target on the entry edge and holds it.
- R7: `tgt_mode` = 1 selects the snapshot target. This is the live offset captured at the DLY_LEN-th most recent sample strobe before entry (DLY_LEN = 8). The output takes it on the entry edge.
- R8: `tgt_mode` = 2 selects the average target. On each strobe outside holdover the average y updates as y = y + ((x − y) >>> `iir_shift`), using an arithmetic shift.
- R9: In `tgt_mode` = 2, the entry edge loads the live offset. After that, each strobe moves the output toward the average by at most `slope_lim`, landing exactly on the average once it is within `slope_lim` of it. Without a strobe, the output does not change.
- R10: During holdover, strobes and live offsets do not alter the stored snapshot or average.
- R11: Holdover persists for as long as all references stay lost. Once any `ref_los` bit is 0, `hold_alarm` clears on the next edge and the live offset passes through again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_ofs | input | OFS_W | Signed live offset from the loop filter |
| sample_stb | input | 1 | History sample / slew update strobe |
| ref_los | input | NUM_REF | Per-reference loss-of-signal flags, 1 = lost |
| tgt_mode | input | 2 | Holdover target: 0/3 centre, 1 snapshot, 2 average |
| slope_lim | input | OFS_W | Unsigned maximum step per strobe in average mode |
| iir_shift | input | SHW | Average filter shift k |
| gap_mode | input | 1 | Gapped-clock entry delay enable |
| mon_period | input | CNT_W | Loss monitor period in clock cycles (at least 1) |
| ofs_out | output | OFS_W | Signed offset applied to the oscillator |
| hold_alarm | output | 1 | High while in holdover |
| evt_pulse | output | 1 | One-cycle pulse on each holdover change |

## Verification
The hardest state to reach is a slewing average-mode holdover whose target is a known value. Both the average and the output start point are only visible indirectly.

To get there, the stimulus first runs a stretch of strobed, patterned live offsets in average mode so the filter settles. It then swings the live word far from the average without strobing and drops every reference. The scoreboard model then follows the bounded steps, strobe by strobe, until the output lands on the frozen average.

A separate run in gapped mode lets the references return one cycle before the wait window expires, and then lets them stay lost past it.

// File: rtl/hold_pkg.sv
package hold_pkg;
    typedef enum logic [1:0] {
        ST_TRACK   = 2'd0,
        ST_GAPWAIT = 2'd1,
        ST_HOLD    = 2'd2
    } hold_st_e;

    localparam logic [1:0] MODE_CENTRE = 2'd0;
    localparam logic [1:0] MODE_SNAP   = 2'd1;
    localparam logic [1:0] MODE_AVG    = 2'd2;
endpackage

// File: rtl/hold_hist.sv
module hold_hist #(
    parameter int W     = 24,
    parameter int DEPTH = 8,
    parameter int SHW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd,
    input  logic [W-1:0]   smp,
    input  logic [SHW-1:0] k,
    output logic [W-1:0]   snap_o,
    output logic [W-1:0]   avg_o
);
    logic [W-1:0] tap_q [DEPTH];

    // shift line: stage 0 takes the new sample, stage g takes stage g-1
    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        logic [W-1:0] tap_d;
        if (g == 0) begin : g_head
            always_comb tap_d = upd ? smp : tap_q[0];
        end else begin : g_body
            always_comb tap_d = upd ? tap_q[g-1] : tap_q[g];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) tap_q[g] <= '0;
            else        tap_q[g] <= tap_d;
        end
    end

    assign snap_o = tap_q[DEPTH-1];

    // first-order low-pass: y += (x - y) >>> k
    logic [W-1:0]        avg_d, avg_q;
    logic signed [W:0]   dif, stp, sum;

    always_comb begin
        dif   = $signed({smp[W-1], smp}) - $signed({avg_q[W-1], avg_q});
        stp   = dif >>> k;
        sum   = $signed({avg_q[W-1], avg_q}) + stp;
        avg_d = avg_q;
        if (upd) begin
            // sum lies between y and x, so the guard never rejects a legal result
            avg_d = (sum[W] == sum[W-1]) ? sum[W-1:0] : avg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) avg_q <= '0;
        else        avg_q <= avg_d;
    end

    assign avg_o = avg_q;
endmodule

// File: rtl/hold_slew.sv
module hold_slew #(
    parameter int W = 24
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] tgt,
    input  logic [W-1:0] lim,
    output logic [W-1:0] nxt
);
    logic signed [W+1:0] dif, lim_x;

    always_comb begin
        dif   = $signed({{2{tgt[W-1]}}, tgt}) - $signed({{2{cur[W-1]}}, cur});
        lim_x = $signed({2'b00, lim});
        if (dif > lim_x)       nxt = cur + lim;
        else if (dif < -lim_x) nxt = cur - lim;
        else                   nxt = tgt;
    end
endmodule

// File: rtl/hold_offset_ctl.sv
module hold_offset_ctl
    import hold_pkg::*;
#(
    parameter int OFS_W   = 24,
    parameter int NUM_REF = 4,
    parameter int DLY_LEN = 8,
    parameter int SHW     = 4,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OFS_W-1:0]   live_ofs,
    input  logic               sample_stb,
    input  logic [NUM_REF-1:0] ref_los,
    input  logic [1:0]         tgt_mode,
    input  logic [OFS_W-1:0]   slope_lim,
    input  logic [SHW-1:0]     iir_shift,
    input  logic               gap_mode,
    input  logic [CNT_W-1:0]   mon_period,
    output logic [OFS_W-1:0]   ofs_out,
    output logic               hold_alarm,
    output logic               evt_pulse
);
    localparam int GW = CNT_W + 1;

    typedef struct packed {
        hold_st_e        st;
        logic [GW-1:0]   cnt;
        logic [OFS_W-1:0] ofs;
        logic            hold;
        logic            evt;
    } ctl_t;

    ctl_t r_q, r_d;

    logic             all_lost, hist_upd, enter;
    logic [GW-1:0]    gap_lim;
    logic [OFS_W-1:0] snap, avg, tgt, slew_nxt;

    assign all_lost = &ref_los;
    assign hist_upd = sample_stb && (r_q.st != ST_HOLD);
    assign gap_lim  = {mon_period, 1'b0} - 1'b1;

    hold_hist #(.W(OFS_W), .DEPTH(DLY_LEN), .SHW(SHW)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (hist_upd),
        .smp    (live_ofs),
        .k      (iir_shift),
        .snap_o (snap),
        .avg_o  (avg)
    );

    always_comb begin
        case (tgt_mode)
            MODE_SNAP: tgt = snap;
            MODE_AVG:  tgt = avg;
            default:   tgt = '0;
        endcase
    end

    hold_slew #(.W(OFS_W)) u_slew (
        .cur (r_q.ofs),
        .tgt (tgt),
        .lim (slope_lim),
        .nxt (slew_nxt)
    );

    always_comb begin
        r_d   = r_q;
        enter = 1'b0;
        case (r_q.st)
            ST_TRACK: begin
                r_d.ofs = live_ofs;
                if (all_lost) begin
                    if (gap_mode) begin
                        r_d.st  = ST_GAPWAIT;
                        r_d.cnt = '0;
                    end else begin
                        enter = 1'b1;
                    end
                end
            end
            ST_GAPWAIT: begin
                r_d.ofs = live_ofs;
                if (!all_lost)              r_d.st = ST_TRACK;
                else if (r_q.cnt == gap_lim) enter = 1'b1;
                else                        r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_HOLD: begin
                if (!all_lost) begin
                    r_d.st   = ST_TRACK;
                    r_d.hold = 1'b0;
                    r_d.ofs  = live_ofs;
                end else if (tgt_mode == MODE_AVG) begin
                    if (sample_stb) r_d.ofs = slew_nxt;
                end else begin
                    r_d.ofs = tgt;
                end
            end
            default: r_d.st = ST_TRACK;
        endcase
        if (enter) begin
            r_d.st   = ST_HOLD;
            r_d.hold = 1'b1;
            r_d.ofs  = (tgt_mode == MODE_AVG) ? live_ofs : tgt;
        end
        r_d.evt = r_d.hold ^ r_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_TRACK, cnt: '0, ofs: '0, hold: 1'b0, evt: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ofs_out    = r_q.ofs;
    assign hold_alarm = r_q.hold;
    assign evt_pulse  = r_q.evt;
endmodule

// File: rtl/hold_offset_ctl_chk.sv
module hold_offset_ctl_chk #(
    parameter int OFS_W   = 24,
    parameter int NUM_REF = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OFS_W-1:0]   live_ofs,
    input logic               sample_stb,
    input logic [NUM_REF-1:0] ref_los,
    input logic [1:0]         tgt_mode,
    input logic [OFS_W-1:0]   slope_lim,
    input logic [OFS_W-1:0]   ofs_out,
    input logic               hold_alarm,
    input logic               evt_pulse
);
    logic             seen_q;
    logic [OFS_W-1:0] prev_q;
    logic signed [OFS_W+1:0] dlt, mag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else begin
            seen_q <= 1'b1;
            prev_q <= ofs_out;
        end
    end

    assign dlt = $signed({{2{ofs_out[OFS_W-1]}}, ofs_out}) - $signed({{2{prev_q[OFS_W-1]}}, prev_q});
    assign mag = (dlt < 0) ? -dlt : dlt;

    // R2
    track_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !hold_alarm) |-> ofs_out == $past(live_ofs));

    // R3
    entry_needs_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_alarm) |-> $past(&ref_los));

    // R4
    evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (hold_alarm != $past(hold_alarm))) |-> evt_pulse);

    // R4
    evt_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> (hold_alarm != $past(hold_alarm)));

    // R6
    centre_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_alarm && ($past(tgt_mode) == 2'd0)) |-> ofs_out == '0);

    // R9
    slew_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hold_alarm && $past(hold_alarm) && ($past(tgt_mode) == 2'd2))
        |-> mag <= $signed({2'b00, $past(slope_lim)}));

    // R9
    slew_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && hold_alarm && $past(hold_alarm) && ($past(tgt_mode) == 2'd2) && !$past(sample_stb))
        |-> $stable(ofs_out));

    // R11
    exit_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_alarm && !(&ref_los)) |=> !hold_alarm);
endmodule

bind hold_offset_ctl hold_offset_ctl_chk #(.OFS_W(OFS_W), .NUM_REF(NUM_REF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .live_ofs   (live_ofs),
    .sample_stb (sample_stb),
    .ref_los    (ref_los),
    .tgt_mode   (tgt_mode),
    .slope_lim  (slope_lim),
    .ofs_out    (ofs_out),
    .hold_alarm (hold_alarm),
    .evt_pulse  (evt_pulse)
);

// File: tb/sim_hold_offset_ctl.sv
module sim_hold_offset_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] live_ofs = '0;
    logic        sample_stb = 1'b0;
    logic [3:0]  ref_los = '0;
    logic [1:0]  tgt_mode = '0;
    logic [23:0] slope_lim = '0;
    logic [3:0]  iir_shift = '0;
    logic        gap_mode = 1'b0;
    logic [15:0] mon_period = 16'd1;
    logic [23:0] ofs_out;
    logic        hold_alarm, evt_pulse;

    always #2.5 clk = ~clk;

    hold_offset_ctl u0 (
        .clk(clk), .rst_n(rst_n), .live_ofs(live_ofs), .sample_stb(sample_stb),
        .ref_los(ref_los), .tgt_mode(tgt_mode), .slope_lim(slope_lim),
        .iir_shift(iir_shift), .gap_mode(gap_mode), .mon_period(mon_period),
        .ofs_out(ofs_out), .hold_alarm(hold_alarm), .evt_pulse(evt_pulse)
    );

    typedef struct {
        int    ofs;
        bit    hold;
        bit    evt;
        bit    chk;
        string tag;
    } exp_t;

    exp_t q[$];
    int   nchk = 0, nerr = 0;
    bit   done = 1'b0;

    // configuration applied at each driven cycle
    int c_mode = 0, c_slope = 0, c_k = 0, c_gap = 0, c_per = 1;

    // reference model state
    int m_st = 0, m_cnt = 0, m_ofs = 0, m_iir = 0;
    bit m_hold = 1'b0;
    int dl [8];

    task automatic model(input int live, input bit stb, input logic [3:0] los, output exp_t e);
        bit all;
        int tgt, d;
        bit enter, old_hold;
        all = (los == 4'hF);
        old_hold = m_hold;
        enter = 1'b0;
        tgt = (c_mode == 1) ? dl[7] : (c_mode == 2) ? m_iir : 0;
        if (m_st != 2 && stb) begin
            for (int j = 7; j > 0; j--) dl[j] = dl[j-1];
            dl[0] = live;
            m_iir = m_iir + ((live - m_iir) >>> c_k);
        end
        case (m_st)
            0: begin
                m_ofs = live;
                if (all) begin
                    if (c_gap != 0) begin m_st = 1; m_cnt = 0; end
                    else enter = 1'b1;
                end
            end
            1: begin
                m_ofs = live;
                if (!all) m_st = 0;
                else if (m_cnt == 2 * c_per - 1) enter = 1'b1;
                else m_cnt++;
            end
            default: begin
                if (!all) begin m_st = 0; m_hold = 1'b0; m_ofs = live; end
                else if (c_mode == 2) begin
                    if (stb) begin
                        d = tgt - m_ofs;
                        if (d > c_slope) m_ofs += c_slope;
                        else if (d < -c_slope) m_ofs -= c_slope;
                        else m_ofs = tgt;
                    end
                end else m_ofs = tgt;
            end
        endcase
        if (enter) begin
            m_st = 2; m_hold = 1'b1;
            m_ofs = (c_mode == 2) ? live : tgt;
        end
        e.ofs = m_ofs; e.hold = m_hold; e.evt = (m_hold != old_hold);
    endtask

    task automatic cyc(input int live, input bit stb, input logic [3:0] los, input string tag);
        exp_t e;
        @(negedge clk);
        live_ofs   = live[23:0];
        sample_stb = stb;
        ref_los    = los;
        tgt_mode   = c_mode[1:0];
        slope_lim  = c_slope[23:0];
        iir_shift  = c_k[3:0];
        gap_mode   = (c_gap != 0);
        mon_period = c_per[15:0];
        model(live, stb, los, e);
        e.chk = 1'b1;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares each registered result one step after its edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                int   got;
                e = q.pop_front();
                got = int'($signed(ofs_out));
                if (e.chk) begin
                    nchk++;
                    if (got != e.ofs || hold_alarm != e.hold || evt_pulse != e.evt) begin
                        nerr++;
                        $display("FAIL %s: ofs=%0d exp %0d hold=%0b exp %0b evt=%0b exp %0b",
                                 e.tag, got, e.ofs, hold_alarm, e.hold, evt_pulse, e.evt);
                    end
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: run did not finish, got running exp done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 8; j++) dl[j] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        nchk++;
        if (ofs_out != 0 || hold_alarm || evt_pulse) begin
            nerr++;
            $display("FAIL R1: ofs=%0d hold=%0b evt=%0b exp 0 0 0", ofs_out, hold_alarm, evt_pulse);
        end
        rst_n = 1'b1;

        // R2 tracking with varied words and strobes
        for (int i = 0; i < 12; i++) cyc(37 * i - 150, (i % 2) == 0, 4'h0, "R2");
        // R3 partial loss has no effect
        for (int i = 0; i < 4; i++) cyc(500 + i, 1'b0, 4'b1110, "R3");
        for (int i = 0; i < 4; i++) cyc(600 + i, 1'b0, 4'b0111, "R3");
        // R4 / R6 immediate entry to centre
        cyc(700, 1'b0, 4'hF, "R4");
        for (int i = 0; i < 5; i++) cyc(710 + i, 1'b0, 4'hF, "R6");
        // R11 long stay, then return
        for (int i = 0; i < 20; i++) cyc(-900 + i, 1'b0, 4'hF, "R11");
        for (int i = 0; i < 4; i++) cyc(800 + i, 1'b0, 4'b1011, "R11");

        // R7 snapshot target
        c_mode = 1;
        for (int i = 1; i <= 12; i++) cyc(100 * i, 1'b1, 4'h0, "R7");
        cyc(9999, 1'b0, 4'h0, "R7");
        cyc(-3000, 1'b0, 4'hF, "R7");
        // R10 strobes during hold leave the snapshot
        for (int i = 0; i < 8; i++) cyc(-2000 + 77 * i, 1'b1, 4'hF, "R10");
        for (int i = 0; i < 3; i++) cyc(50 + i, 1'b0, 4'h0, "R11");

        // R8 average build-up
        c_mode = 2; c_k = 2; c_slope = 300;
        for (int i = 0; i < 16; i++) cyc(2000 + (i % 3) * 40, 1'b1, 4'h0, "R8");
        cyc(-4000, 1'b0, 4'h0, "R9");
        // R9 entry holds live word, then bounded steps
        cyc(-4000, 1'b0, 4'hF, "R9");
        for (int i = 0; i < 50; i++) cyc(123 * i, (i % 2) == 0, 4'hF, "R9");
        // R8 landed on frozen average (R10)
        for (int i = 0; i < 6; i++) cyc(-7000, 1'b1, 4'hF, "R8");
        for (int i = 0; i < 3; i++) cyc(10 + i, 1'b0, 4'h0, "R11");

        // R5 gapped: short loss cancelled, long loss enters late
        c_mode = 0; c_gap = 1; c_per = 5;
        for (int i = 0; i < 9; i++) cyc(300 + i, 1'b0, 4'hF, "R5");
        for (int i = 0; i < 2; i++) cyc(400 + i, 1'b0, 4'h0, "R5");
        for (int i = 0; i < 14; i++) cyc(500 + i, 1'b0, 4'hF, "R5");
        for (int i = 0; i < 2; i++) cyc(600 + i, 1'b0, 4'h0, "R11");

        // R6 code 3 behaves as centre
        c_gap = 0; c_mode = 3;
        for (int i = 0; i < 4; i++) cyc(900 + i, 1'b0, 4'hF, "R6");
        for (int i = 0; i < 2; i++) cyc(950 + i, 1'b0, 4'h0, "R11");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule